// File: doc/BRIEF.md
# Dual-Register Phase-Accumulator Synthesizer

This core produces one digital amplitude sample per reference clock from a running phase. A 28-bit accumulator adds a tuning word on every edge and wraps freely, so the output frequency is the clock rate times the tuning word divided by 2^28. Two tuning words and two 12-bit phase offsets are kept in a small register bank; two select inputs pick which tuning word feeds the accumulator and which offset is added to its output. The offset-shifted phase then drives a waveform stage that returns a sine, a triangle or a square sample, or silence.

Software or a sequencer loads the bank through a one-cycle write strobe with a 2-bit address. A synchronous reset clears the accumulator and forces the sample to zero. Reset leaves the bank writable, so a full setting can be loaded while the core is held and generation begins cleanly when reset drops. Switching between the two preloaded tuning words or offsets is a single select toggle. This is what makes fast frequency hops and phase steps possible.

Top module: `dds_core`

## Requirements
- R1: When `rst` is low at a rising edge, `acc_o` becomes `acc_o` plus the selected tuning word, modulo 2^28.
- R2: `freq_sel` (0 or 1) picks the tuning word the accumulator adds at the edge where it is sampled.
- R3: `phase_sel` picks a 12-bit offset that is placed in phase bits 27..16 and added to the accumulator. A change of offset or select reaches `sample_o` two edges later.
- R4: Write addresses: 0 loads tuning word 0 and 1 loads tuning word 1, each from `wr_data[27:0]`. Addresses 2 and 3 load offsets 0 and 1 from `wr_data[11:0]`. A written value is used from the next edge on. At the write edge itself the accumulator still adds the old word.
- R5: n edges after reset is released, with both selects held at 0, `acc_o` equals n·F mod 2^28. `sample_o` is the waveform of phase (max(n−2,0)·F + offset·2^16) mod 2^28.
- R6: Mode 0 (sine). Let p be phase bits 27..18 and q = round(511.5·|sin(2π(p+0.5)/1024)|). The sample is 512+q for p<512 and 511−q otherwise.
- R7: Mode 1 (triangle). Let b be phase bits 26..17. The sample is b when phase bit 27 is 0 and the bitwise inverse of b when it is 1.
- R8: Mode 2 (square) gives 1023 when phase bit 27 is 1 and 0 otherwise. Mode 3 gives 0.
- R9: An edge with `rst` high clears `acc_o` and `sample_o` to 0. Writes made while `rst` is high still land in the register bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (see R4) |
| wr_data | input | 28 | Write data |
| freq_sel | input | 1 | Tuning word select |
| phase_sel | input | 1 | Phase offset select |
| wave_mode | input | 2 | 0 sine, 1 triangle, 2 square, 3 off |
| acc_o | output | 28 | Phase accumulator value |
| sample_o | output | 10 | Unsigned amplitude sample |

## Verification
The collision that matters is a write to the tuning word that the accumulator is using at that very edge. Both the accumulation and the register update happen on the same clock. The bench provokes this by issuing a write to the active register mid-run and reading `acc_o` before and after. The result is judged correct only if the write edge added the old word and every later edge added the new one. A second case, a select toggle that lands while the phase pipeline is in flight, is judged by when the sample moves: one edge after the toggle it must not have moved, and two edges after it must have.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_TRI    = 2'd1,
    WAVE_SQUARE = 2'd2,
    WAVE_OFF    = 2'd3
  } wave_e;

  localparam int unsigned BANK_N = 2;
endpackage

// File: rtl/dds_tuning_regs.sv
`timescale 1ns/1ps
module dds_tuning_regs #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             freq_sel,
  input  logic             phase_sel,
  output logic [ACC_W-1:0] inc_o,
  output logic [OFS_W-1:0] ofs_o
);
  import dds_pkg::*;

  // wr_addr[1] picks the bank (0 tuning, 1 offset), wr_addr[0] the entry
  logic [ACC_W-1:0] freq_q  [BANK_N] = '{default: '0};
  logic [OFS_W-1:0] phase_q [BANK_N] = '{default: '0};

  always_ff @(posedge clk) begin
    for (int i = 0; i < BANK_N; i++) begin
      if (wr_en && !wr_addr[1] && (wr_addr[0] == i[0]))
        freq_q[i] <= wr_data;
      if (wr_en && wr_addr[1] && (wr_addr[0] == i[0]))
        phase_q[i] <= wr_data[OFS_W-1:0];
    end
  end

  assign inc_o = freq_q[freq_sel];
  assign ofs_o = phase_q[phase_sel];

  // R4: a tuning write is present in the bank one edge later
  a_r4_freq_lands: assert property (@(posedge clk)
    (wr_en && !wr_addr[1]) |=> freq_q[$past(wr_addr[0])] == $past(wr_data));

  // R4: an offset write keeps only its low bits
  a_r4_phase_lands: assert property (@(posedge clk)
    (wr_en && wr_addr[1]) |=> phase_q[$past(wr_addr[0])] == $past(wr_data[OFS_W-1:0]));
endmodule

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned OFS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [ACC_W-1:0] phase_o
);
  localparam int unsigned PAD_W = ACC_W - OFS_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] ofs_wide;

  assign ofs_wide = {ofs_i, {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + inc_i;
  end

  // offset stage is free-running; reset only pins the accumulator
  always_ff @(posedge clk) begin
    phase_q <= acc_q + ofs_wide;
  end

  assign acc_o   = acc_q;
  assign phase_o = phase_q;

  // R1: modular advance by the word presented at the previous edge
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc_q == ACC_W'($past(acc_q) + $past(inc_i)));

  // R9: reset clears the accumulator
  a_r9_acc_clear: assert property (@(posedge clk)
    rst |=> acc_q == '0);
endmodule

// File: rtl/dds_wave_gen.sv
`timescale 1ns/1ps
module dds_wave_gen #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  dds_pkg::wave_e   mode_i,
  input  logic [ACC_W-1:0] phase_i,
  output logic [AMP_W-1:0] sample_o
);
  import dds_pkg::*;

  localparam int unsigned QW     = AMP_W - 2;
  localparam int unsigned QN     = 1 << QW;
  localparam int unsigned ROM_W  = AMP_W - 1;
  localparam int unsigned HALF   = 1 << (AMP_W - 1);
  localparam real         PI2    = 6.283185307179586;
  localparam real         PEAK   = real'(HALF) - 0.5;

  // quarter-wave table, computed at start-up
  logic [ROM_W-1:0] rom [QN];

  initial begin
    for (int i = 0; i < QN; i++) begin
      rom[i] = ROM_W'($rtoi(PEAK * $sin(PI2 * (real'(i) + 0.5) / real'(4 * QN)) + 0.5));
    end
  end

  logic [AMP_W-1:0] top;
  logic [1:0]       quad;
  logic [QW-1:0]    idx;
  logic [QW-1:0]    ridx;
  logic [ROM_W-1:0] qval;
  logic [AMP_W-1:0] sine_s;
  logic [AMP_W-1:0] tri_s;
  logic [AMP_W-1:0] sq_s;
  logic [AMP_W-1:0] next_s;
  logic [AMP_W-1:0] sample_q;

  assign top  = phase_i[ACC_W-1 -: AMP_W];
  assign quad = top[AMP_W-1 -: 2];
  assign idx  = top[QW-1:0];
  assign ridx = quad[0] ? ~idx : idx;
  assign qval = rom[ridx];

  always_comb begin
    if (quad[1]) sine_s = AMP_W'(HALF - 1) - AMP_W'(qval);
    else         sine_s = AMP_W'(HALF) + AMP_W'(qval);
  end

  assign tri_s = phase_i[ACC_W-1] ? ~phase_i[ACC_W-2 -: AMP_W] : phase_i[ACC_W-2 -: AMP_W];
  assign sq_s  = {AMP_W{phase_i[ACC_W-1]}};

  always_comb begin
    unique case (mode_i)
      WAVE_SINE:   next_s = sine_s;
      WAVE_TRI:    next_s = tri_s;
      WAVE_SQUARE: next_s = sq_s;
      default:     next_s = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sample_q <= '0;
    else     sample_q <= next_s;
  end

  assign sample_o = sample_q;

  // R9: output held at zero by reset
  a_r9_out_zero: assert property (@(posedge clk)
    rst |=> sample_q == '0);

  // R8: square output only takes the two rails
  a_r8_square_rails: assert property (@(posedge clk) disable iff (rst)
    (mode_i == WAVE_SQUARE) |=> (sample_q == '0 || sample_q == '1));

  // R8: off mode is silent
  a_r8_off_silent: assert property (@(posedge clk) disable iff (rst)
    (mode_i == WAVE_OFF) |=> sample_q == '0);

  // R6: sine upper half for the first half of the cycle
  a_r6_sine_half: assert property (@(posedge clk) disable iff (rst)
    (mode_i == WAVE_SINE && !phase_i[ACC_W-1]) |=> sample_q[AMP_W-1]);
endmodule

// File: rtl/dds_core.sv
`timescale 1ns/1ps
module dds_core #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             freq_sel,
  input  logic             phase_sel,
  input  logic [1:0]       wave_mode,
  output logic [ACC_W-1:0] acc_o,
  output logic [AMP_W-1:0] sample_o
);
  import dds_pkg::*;

  logic [ACC_W-1:0] inc;
  logic [OFS_W-1:0] ofs;
  logic [ACC_W-1:0] phase;
  wave_e            mode;

  assign mode = wave_e'(wave_mode);

  dds_tuning_regs #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_sel(freq_sel), .phase_sel(phase_sel), .inc_o(inc), .ofs_o(ofs)
  );

  dds_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_acc (
    .clk(clk), .rst(rst), .inc_i(inc), .ofs_i(ofs),
    .acc_o(acc_o), .phase_o(phase)
  );

  dds_wave_gen #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_wave (
    .clk(clk), .rst(rst), .mode_i(mode), .phase_i(phase), .sample_o(sample_o)
  );

  // R2: with select held, consecutive steps use the same bank word
  a_r2_select_step: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && $stable(freq_sel)) |=> ACC_W'(acc_o - $past(acc_o)) == $past(inc));
endmodule

// File: tb/tb_dds_core.sv
`timescale 1ns/1ps
module tb_dds_core;
  localparam int ACC_W = 28;
  localparam int OFS_W = 12;
  localparam int AMP_W = 10;
  localparam int NV    = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [ACC_W-1:0] wr_data = '0;
  logic             freq_sel = 1'b0;
  logic             phase_sel = 1'b0;
  logic [1:0]       wave_mode = '0;
  logic [ACC_W-1:0] acc_o;
  logic [AMP_W-1:0] sample_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dds_core dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_sel(freq_sel), .phase_sel(phase_sel), .wave_mode(wave_mode),
    .acc_o(acc_o), .sample_o(sample_o)
  );

  // vector table: tuning word, offset, mode, edges after release
  localparam logic [27:0] V_F [NV] = '{28'h0100000, 28'h0123457, 28'hFFFFFFF, 28'h8000000,
                                       28'h0000001, 28'h3000000, 28'h0ABCDEF, 28'h0000000};
  localparam logic [11:0] V_O [NV] = '{12'h000, 12'h400, 12'h000, 12'h000,
                                       12'h800, 12'hFFF, 12'h123, 12'h200};
  localparam logic [1:0]  V_M [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd2, 2'd1, 2'd3, 2'd0};
  localparam int          V_N [NV] = '{5, 9, 7, 6, 4, 10, 8, 3};

  function automatic int exp_wave(logic [27:0] ph, logic [1:0] m);
    int p;
    real s;
    int q;
    p = int'(ph[27:18]);
    case (m)
      2'd0: begin
        s = $sin(6.283185307179586 * (real'(p) + 0.5) / 1024.0);
        if (s < 0.0) s = -s;
        q = $rtoi(511.5 * s + 0.5);
        return (p < 512) ? 512 + q : 511 - q;
      end
      2'd1: return ph[27] ? int'(~ph[26:17]) & 1023 : int'(ph[26:17]);
      2'd2: return ph[27] ? 1023 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one write, consumes one rising edge; called at a falling edge
  task automatic wr(logic [1:0] a, logic [27:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [27:0] base;
    logic [27:0] ea;
    logic [27:0] ph;
    int k;
    @(negedge clk);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      rst = 1'b1;
      freq_sel = 1'b0; phase_sel = 1'b0; wave_mode = V_M[v];
      wr(2'd0, V_F[v]);                 // R9: writes during reset
      wr(2'd2, {16'h0, V_O[v]});
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R9 acc in reset", acc_o, 0);
      check("R9 sample in reset", sample_o, 0);
      rst = 1'b0;
      repeat (V_N[v]) @(posedge clk);
      @(negedge clk);
      ea = 28'(longint'(V_N[v]) * longint'(V_F[v]));
      k  = (V_N[v] >= 2) ? V_N[v] - 2 : 0;
      ph = 28'(longint'(k) * longint'(V_F[v]) + (longint'(V_O[v]) << 16));
      check("R1 R5 accumulator", acc_o, ea);
      check("R5 R6 R7 R8 sample", sample_o, exp_wave(ph, V_M[v]));
    end

    // R9: reset mid-run clears after one edge
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 clear acc", acc_o, 0);
    check("R9 clear sample", sample_o, 0);

    // R2: select switching between two tuning words
    wr(2'd0, 28'h0001000);
    wr(2'd1, 28'h0030000);
    wr(2'd2, 28'h0);
    wave_mode = 2'd2; freq_sel = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    freq_sel = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R2 select hop", acc_o, 28'(3 * 28'h0001000 + 4 * 28'h0030000));

    // R4: write to the active word at the edge it is used
    base = acc_o;
    wr(2'd1, 28'h0000500);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 same-edge write", acc_o, 28'(base + 28'h0030000 + 2 * 28'h0000500));

    // R3: offset select toggle with zero tuning word, square mode
    rst = 1'b1;
    wr(2'd0, 28'h0);
    wr(2'd3, 28'h800);
    freq_sel = 1'b0; phase_sel = 1'b0; wave_mode = 2'd2;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 offset 0", sample_o, 0);
    phase_sel = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 one edge later", sample_o, 0);
    @(posedge clk); @(negedge clk);
    check("R3 two edges later", sample_o, 1023);

    // R8: mode 3 silences, back to square restores after one edge
    wave_mode = 2'd3;
    @(posedge clk); @(negedge clk);
    check("R8 off", sample_o, 0);
    wave_mode = 2'd2;
    @(posedge clk); @(negedge clk);
    check("R8 square high", sample_o, 1023);

    // R4: offset write keeps only low 12 bits
    wr(2'd3, 28'hFFFF000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R4 offset low bits", sample_o, 0);

    finish_run();
  end
endmodule